// File: doc/BRIEF.md
# NAND Erase / Program Sequencer with Status Check

This block runs one block erase or one page program against a NAND flash device. It issues the command, address and data beats on a byte-wide bus, one beat per clock. After the confirm command it waits for the device to finish, reads the status byte and reports pass, fail, timeout, abort or reject. The number of the block that was operated on is reported with every result, so a controller can retire a block after a failure.

Completion is detected in one of two ways, chosen per request. In ready-pin mode the block watches the ready/busy line. In polling mode it sends a status command and re-reads the status byte until the ready bit is set. In both modes the ready line is not sampled during a short blanking window after the confirm beat. The device is still settling into its busy state during that window.

Within a block, pages must be programmed in rising order. The sequencer keeps the last programmed page of every block in a small table. A request that would go backwards, or repeat a page, is refused without any bus activity. An erase forgets the block's history. A separate abort input, or a wait that runs too long, ends the operation with a reset command.

Top module: `nand_ops_sequencer`

## Requirements
- R1: An erase emits command 60h, then three address beats carrying the row number low byte first (row = block shifted left by PAGE_W, page bits zero), then command D0h.
- R2: A program emits command 80h, then five address beats (two column bytes of 00h, then the three row bytes low first, row = block * 2^PAGE_W + page), then BURST_LEN data beats taking `wr_byte` in order, with `data_take` high on each, then command 10h.
- R3: Each beat is a single cycle of `bus_we`. `bus_cle` is high for a command beat, `bus_ale` is high for an address beat, and both are low for a data beat. The two are never high together, and both are low when `bus_we` is low.
- R4: For WB_CYC cycles after the confirm beat, `nand_rdy` is ignored. In ready-pin mode the status command 70h is issued once `nand_rdy` is high after that window. With the device already ready, it appears exactly WB_CYC+2 cycles after the confirm beat.
- R5: In polling mode the block issues 70h once after the window. It then pulses `stat_rd` and waits for `st_valid`, repeating until status bit 6 is 1.
- R6: When a status byte with bit 6 set arrives, status bit 0 selects the result: 0 gives PASS (code 0) and 1 gives FAIL (code 1). `done` pulses for one cycle with `result` and `op_block` valid, and `busy` falls in the same cycle.
- R7: If completion is not seen within TIMEOUT_CYC cycles of the confirm beat, the block issues command FFh and reports TIMEOUT (code 2).
- R8: `abort_req` while waiting for completion issues command FFh and reports ABORT (code 4).
- R9: A program whose page is not above the last page accepted for the same block reports REJECT (code 3) with no bus beat. Other blocks are unaffected.
- R10: An erase makes its block untracked, so page 0 is accepted again. A program that reaches its confirm beat records its page, even if it then fails, times out or is aborted.
- R11: During reset, and while the page table clears after reset, `busy` is high and no beat is issued. Afterwards every block is untracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operation (taken when `busy` is low) |
| req_erase | input | 1 | 1 = block erase, 0 = page program |
| req_poll | input | 1 | 1 = status polling, 0 = ready pin |
| req_block | input | BLK_W | Target block |
| req_page | input | PAGE_W | Target page (program only) |
| wr_byte | input | 8 | Current program data byte |
| abort_req | input | 1 | Abort a pending wait |
| nand_rdy | input | 1 | Device ready/busy line, high = ready |
| st_valid | input | 1 | Status byte returned |
| st_byte | input | 8 | Status byte |
| busy | output | 1 | Sequencer occupied |
| bus_we | output | 1 | Beat strobe |
| bus_cle | output | 1 | Beat is a command |
| bus_ale | output | 1 | Beat is an address |
| bus_byte | output | 8 | Beat value |
| data_take | output | 1 | `wr_byte` consumed this cycle |
| stat_rd | output | 1 | Request one status byte |
| done | output | 1 | Result strobe |
| result | output | 3 | 0 pass, 1 fail, 2 timeout, 3 reject, 4 abort |
| op_block | output | BLK_W | Block of the reported operation |

## Verification
The in-RTL assertions check the following on every cycle: beat-type exclusivity, the blanking window before the first status command, the single-cycle result strobe, the silent path of a refused program, the jump to the reset beat once the timer expires, and the quiet bus during the table clear. Only the bench scenarios can show the beat sequences and their values, and pass versus fail from the status bit. They also show the per-block page ordering across several operations, an erase re-opening a block, and an abort. The bench's device model and beat queue are compared against the outputs on every clock.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    RES_PASS    = 3'd0,
    RES_FAIL    = 3'd1,
    RES_TIMEOUT = 3'd2,
    RES_REJECT  = 3'd3,
    RES_ABORT   = 3'd4
  } res_e;

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_LOOK, S_CMD1, S_ADDR, S_DATA, S_CONF,
    S_WAIT, S_STCMD, S_STRD, S_STWAIT, S_RST, S_FIN
  } seq_state_e;

  localparam logic [7:0] OPC_ERS_OPEN  = 8'h60;
  localparam logic [7:0] OPC_ERS_GO    = 8'hD0;
  localparam logic [7:0] OPC_PRG_OPEN  = 8'h80;
  localparam logic [7:0] OPC_PRG_GO    = 8'h10;
  localparam logic [7:0] OPC_STATUS    = 8'h70;
  localparam logic [7:0] OPC_RESET     = 8'hFF;

endpackage

// File: rtl/page_order_table.sv
module page_order_table #(
  parameter int BLK_W  = 4,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic              rd_hit,
  output logic [PAGE_W-1:0] rd_page,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              wr_hit,
  input  logic [PAGE_W-1:0] wr_page,
  output logic              ready
);
  localparam int NBLK = 1 << BLK_W;

  logic [PAGE_W:0]    mem [NBLK];
  logic [PAGE_W:0]    rd_q;
  logic [BLK_W-1:0]   sweep;
  logic               sweeping;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping <= 1'b1;
      sweep    <= '0;
    end else if (sweeping) begin
      sweep <= sweep + 1'b1;
      if (sweep == BLK_W'(NBLK - 1)) sweeping <= 1'b0;
    end
  end

  // single write port, single registered read port
  always_ff @(posedge clk) begin
    if (sweeping)   mem[sweep]  <= '0;
    else if (wr_en) mem[wr_blk] <= {wr_hit, wr_page};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_blk];
  end

  assign rd_hit  = rd_q[PAGE_W];
  assign rd_page = rd_q[PAGE_W-1:0];
  assign ready   = !sweeping;

  assert_no_write_in_clear_R11: assert property (@(posedge clk) disable iff (rst)
    sweeping |-> !wr_en);
  assert_no_read_in_clear_R11: assert property (@(posedge clk) disable iff (rst)
    sweeping |-> !rd_en);

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int W     = 20,
  parameter int LIMIT = 1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         expired
);
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start)          cnt <= '0;
    else if (run && cnt != '1) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= W'(LIMIT));

  assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/nand_ops_sequencer.sv
module nand_ops_sequencer
  import nand_seq_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int PAGE_W      = 6,
  parameter int BURST_LEN   = 2112,
  parameter int WB_CYC      = 13,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic              req_poll,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [7:0]        wr_byte,
  input  logic              abort_req,
  input  logic              nand_rdy,
  input  logic              st_valid,
  input  logic [7:0]        st_byte,
  output logic              busy,
  output logic              bus_we,
  output logic              bus_cle,
  output logic              bus_ale,
  output logic [7:0]        bus_byte,
  output logic              data_take,
  output logic              stat_rd,
  output logic              done,
  output logic [2:0]        result,
  output logic [BLK_W-1:0]  op_block
);
  localparam int ROW_W  = BLK_W + PAGE_W;
  localparam int DCNT_W = $clog2(BURST_LEN + 1);
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + 2);

  seq_state_e         st;
  logic               erase_q, poll_q;
  logic [BLK_W-1:0]   blk_q;
  logic [PAGE_W-1:0]  page_q;
  logic [2:0]         aidx;
  logic [DCNT_W-1:0]  didx;
  res_e               pend_res;

  logic               tbl_ready, tbl_rd_en, tbl_hit, tbl_wr_en;
  logic [PAGE_W-1:0]  tbl_last;
  logic               tmr_start, tmr_run, tmr_exp;
  logic [TMR_W-1:0]   tmr_cnt;
  logic               blank_ok, refuse;
  logic [23:0]        row24;
  logic [2:0]         rsel;
  logic [7:0]         abyte;
  logic               alast;

  assign tbl_rd_en = (st == S_IDLE) && req_valid && tbl_ready;
  assign tbl_wr_en = (st == S_CONF);

  page_order_table #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(tbl_rd_en), .rd_blk(req_block), .rd_hit(tbl_hit), .rd_page(tbl_last),
    .wr_en(tbl_wr_en), .wr_blk(blk_q), .wr_hit(!erase_q), .wr_page(page_q),
    .ready(tbl_ready)
  );

  assign tmr_start = (st == S_CONF);
  assign tmr_run   = (st == S_WAIT) || (st == S_STCMD) || (st == S_STRD) || (st == S_STWAIT);

  wait_timer #(.W(TMR_W), .LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .run(tmr_run),
    .cnt(tmr_cnt), .expired(tmr_exp)
  );

  assign blank_ok = (tmr_cnt >= TMR_W'(WB_CYC));
  assign refuse   = !erase_q && tbl_hit && (page_q <= tbl_last);
  assign row24    = 24'({blk_q, page_q});

  always_comb begin
    rsel  = erase_q ? aidx : (aidx - 3'd2);
    alast = erase_q ? (aidx == 3'd2) : (aidx == 3'd4);
    case (rsel)
      3'd0:    abyte = row24[7:0];
      3'd1:    abyte = row24[15:8];
      3'd2:    abyte = row24[23:16];
      default: abyte = 8'h00;
    endcase
    if (!erase_q && aidx < 3'd2) abyte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_INIT;
      busy      <= 1'b1;
      bus_we    <= 1'b0;
      bus_cle   <= 1'b0;
      bus_ale   <= 1'b0;
      bus_byte  <= 8'h00;
      data_take <= 1'b0;
      stat_rd   <= 1'b0;
      done      <= 1'b0;
      result    <= 3'd0;
      op_block  <= '0;
      erase_q   <= 1'b0;
      poll_q    <= 1'b0;
      blk_q     <= '0;
      page_q    <= '0;
      aidx      <= '0;
      didx      <= '0;
      pend_res  <= RES_PASS;
    end else begin
      bus_we    <= 1'b0;
      bus_cle   <= 1'b0;
      bus_ale   <= 1'b0;
      data_take <= 1'b0;
      stat_rd   <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_INIT: if (tbl_ready) begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        S_IDLE: if (req_valid && tbl_ready) begin
          busy    <= 1'b1;
          erase_q <= req_erase;
          poll_q  <= req_poll;
          blk_q   <= req_block;
          page_q  <= req_erase ? '0 : req_page;
          st      <= S_LOOK;
        end
        S_LOOK: if (refuse) begin
          pend_res <= RES_REJECT;
          st       <= S_FIN;
        end else begin
          st <= S_CMD1;
        end
        S_CMD1: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_byte <= erase_q ? OPC_ERS_OPEN : OPC_PRG_OPEN;
          aidx     <= '0;
          st       <= S_ADDR;
        end
        S_ADDR: begin
          bus_we   <= 1'b1;
          bus_ale  <= 1'b1;
          bus_byte <= abyte;
          aidx     <= aidx + 1'b1;
          didx     <= '0;
          if (alast) st <= erase_q ? S_CONF : S_DATA;
        end
        S_DATA: begin
          bus_we    <= 1'b1;
          bus_byte  <= wr_byte;
          data_take <= 1'b1;
          didx      <= didx + 1'b1;
          if (didx == DCNT_W'(BURST_LEN - 1)) st <= S_CONF;
        end
        S_CONF: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_byte <= erase_q ? OPC_ERS_GO : OPC_PRG_GO;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          if (abort_req) begin
            pend_res <= RES_ABORT;
            st       <= S_RST;
          end else if (tmr_exp) begin
            pend_res <= RES_TIMEOUT;
            st       <= S_RST;
          end else if (blank_ok && (poll_q || nand_rdy)) begin
            st <= S_STCMD;
          end
        end
        S_STCMD: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_byte <= OPC_STATUS;
          st       <= S_STRD;
        end
        S_STRD: begin
          if (abort_req) begin
            pend_res <= RES_ABORT;
            st       <= S_RST;
          end else if (tmr_exp) begin
            pend_res <= RES_TIMEOUT;
            st       <= S_RST;
          end else begin
            stat_rd <= 1'b1;
            st      <= S_STWAIT;
          end
        end
        S_STWAIT: begin
          if (abort_req) begin
            pend_res <= RES_ABORT;
            st       <= S_RST;
          end else if (tmr_exp) begin
            pend_res <= RES_TIMEOUT;
            st       <= S_RST;
          end else if (st_valid) begin
            if (st_byte[6]) begin
              pend_res <= st_byte[0] ? RES_FAIL : RES_PASS;
              st       <= S_FIN;
            end else begin
              st <= S_STRD;
            end
          end
        end
        S_RST: begin
          bus_we   <= 1'b1;
          bus_cle  <= 1'b1;
          bus_byte <= OPC_RESET;
          st       <= S_FIN;
        end
        S_FIN: begin
          done     <= 1'b1;
          result   <= pend_res;
          op_block <= blk_q;
          busy     <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_beat_kind_excl_R3: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> !(bus_cle && bus_ale));
  assert_no_strobe_no_kind_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_we |-> (!bus_cle && !bus_ale));
  assert_blank_window_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_STCMD) |-> (tmr_cnt > TMR_W'(WB_CYC)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_timeout_reset_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && tmr_exp && !abort_req) |=> (st == S_RST));
  assert_refuse_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && refuse) |=> (!bus_we && st == S_FIN));
  assert_quiet_init_R11: assert property (@(posedge clk) disable iff (rst)
    (st == S_INIT) |-> (!bus_we && busy));

endmodule

// File: tb/test_nand_ops_sequencer.sv
module test_nand_ops_sequencer;
  localparam int BLK_W = 3, PAGE_W = 4, BURST = 8, WB = 12, TOUT = 300;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_erase = 0, req_poll = 0;
  logic [BLK_W-1:0] req_block = '0;
  logic [PAGE_W-1:0] req_page = '0;
  logic [7:0] wr_byte = 0;
  logic abort_req = 0, nand_rdy = 1, st_valid = 0;
  logic [7:0] st_byte = 0;
  logic busy, bus_we, bus_cle, bus_ale, data_take, stat_rd, done;
  logic [7:0] bus_byte;
  logic [2:0] result;
  logic [BLK_W-1:0] op_block;

  nand_ops_sequencer #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .BURST_LEN(BURST),
    .WB_CYC(WB), .TIMEOUT_CYC(TOUT)) i_nand_ops_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_poll(req_poll), .req_block(req_block), .req_page(req_page),
    .wr_byte(wr_byte), .abort_req(abort_req), .nand_rdy(nand_rdy),
    .st_valid(st_valid), .st_byte(st_byte), .busy(busy), .bus_we(bus_we),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_byte(bus_byte),
    .data_take(data_take), .stat_rd(stat_rd), .done(done), .result(result),
    .op_block(op_block));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [9:0] expq[$];
  string cur_req = "R11";
  int beat_cnt = 0, stat_cnt = 0, dcount = 0;
  int conf_cyc = -1, st70_cyc = -1;
  bit conf_seen = 0;
  int dev_busy_set = 0, dev_cnt = 0;
  bit dev_rdy = 1, dev_fail = 0, st_pend = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // beat monitor plus behavioural device, evaluated between edges
  always @(negedge clk) begin
    cyc++;
    if (dev_cnt > 0) begin
      dev_cnt--;
      if (dev_cnt == 0) dev_rdy = 1;
    end
    if (bus_we) begin
      logic [1:0] kind;
      beat_cnt++;
      chk(!(bus_cle && bus_ale), "R3", "cle and ale together", 1, 0);
      kind = bus_cle ? 2'd1 : (bus_ale ? 2'd2 : 2'd3);
      if (expq.size() == 0) chk(0, cur_req, "unexpected beat", int'({kind, bus_byte}), 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({kind, bus_byte} == e, cur_req, "beat", int'({kind, bus_byte}), int'(e));
      end
      if (bus_cle && (bus_byte == 8'hD0 || bus_byte == 8'h10)) begin
        conf_seen = 1; conf_cyc = cyc;
        dev_cnt = dev_busy_set; dev_rdy = (dev_busy_set == 0);
      end
      if (bus_cle && bus_byte == 8'h70 && st70_cyc < 0) st70_cyc = cyc;
      if (bus_cle && bus_byte == 8'hFF) begin dev_rdy = 1; dev_cnt = 0; end
    end else if (bus_cle || bus_ale) chk(0, "R3", "kind without strobe", 1, 0);
    if (st_pend) begin
      st_valid = 1; st_byte = {1'b0, dev_rdy, 5'b0, dev_fail}; st_pend = 0;
    end else st_valid = 0;
    if (stat_rd) begin st_pend = 1; stat_cnt++; end
    if (data_take) begin dcount++; wr_byte = pat(dcount); end
    nand_rdy = dev_rdy;
  end

  task automatic run_op(bit er, bit poll, int blk, int pg, int dbusy, bit dfail,
                        int abort_after, int exp_res, string req,
                        bit exp_bus, bit exp_st, bit exp_ff);
    int row, waited;
    row = er ? blk * (1 << PAGE_W) : blk * (1 << PAGE_W) + pg;
    expq.delete();
    if (exp_bus) begin
      expq.push_back({2'd1, er ? 8'h60 : 8'h80});
      if (!er) begin expq.push_back({2'd2, 8'h00}); expq.push_back({2'd2, 8'h00}); end
      expq.push_back({2'd2, 8'(row)});
      expq.push_back({2'd2, 8'(row >> 8)});
      expq.push_back({2'd2, 8'(row >> 16)});
      if (!er) for (int i = 0; i < BURST; i++) expq.push_back({2'd3, pat(i)});
      expq.push_back({2'd1, er ? 8'hD0 : 8'h10});
      if (exp_st) expq.push_back({2'd1, 8'h70});
      if (exp_ff) expq.push_back({2'd1, 8'hFF});
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    cur_req = req; beat_cnt = 0; stat_cnt = 0; conf_seen = 0;
    conf_cyc = -1; st70_cyc = -1; dcount = 0; wr_byte = pat(0);
    dev_busy_set = dbusy; dev_fail = dfail;
    req_erase = er; req_poll = poll; req_block = BLK_W'(blk); req_page = PAGE_W'(pg);
    req_valid = 1;
    @(negedge clk); req_valid = 0;
    if (abort_after > 0) begin
      while (!conf_seen) @(negedge clk);
      repeat (abort_after) @(negedge clk);
      abort_req = 1; @(negedge clk); abort_req = 0;
    end
    waited = 0;
    while (!done && waited < 3000) begin @(negedge clk); waited++; end
    chk(done, req, "done seen", int'(done), 1);
    chk(result == 3'(exp_res), req, "result", int'(result), exp_res);
    chk(op_block == BLK_W'(blk), "R6", "op_block", int'(op_block), blk);
    chk(!busy, "R6", "busy with done", int'(busy), 0);
    chk(expq.size() == 0, req, "beats missing", expq.size(), 0);
    if (!exp_bus) chk(beat_cnt == 0, "R9", "beats on refused program", beat_cnt, 0);
    @(negedge clk);
    chk(!done, "R6", "done single cycle", int'(done), 0);
  endtask

  initial begin
    int w;
    repeat (5) @(negedge clk);
    chk(busy == 1 && done == 0 && bus_we == 0, "R11", "reset state", int'({busy, done, bus_we}), 4);
    rst = 0;
    w = 0;
    while (busy && w < 200) begin @(negedge clk); w++; end
    chk(!busy, "R11", "busy after table clear", int'(busy), 0);
    chk(beat_cnt == 0, "R11", "beats during clear", beat_cnt, 0);

    run_op(1, 0, 2, 0, 40, 0, 0, 0, "R1", 1, 1, 0);
    chk(st70_cyc - conf_cyc > 40, "R4", "70h before ready", st70_cyc - conf_cyc, 41);
    run_op(0, 1, 2, 0, 40, 0, 0, 0, "R2", 1, 1, 0);
    chk(stat_cnt >= 2, "R5", "status re-polled", stat_cnt, 2);
    run_op(0, 0, 2, 3, 30, 1, 0, 1, "R6", 1, 1, 0);
    run_op(0, 0, 2, 3, 0, 0, 0, 3, "R9", 0, 0, 0);
    run_op(0, 1, 2, 1, 0, 0, 0, 3, "R9", 0, 0, 0);
    run_op(0, 0, 5, 0, 10, 0, 0, 0, "R9", 1, 1, 0);
    run_op(1, 0, 2, 0, 20, 0, 0, 0, "R10", 1, 1, 0);
    run_op(0, 1, 2, 0, 20, 0, 0, 0, "R10", 1, 1, 0);
    run_op(1, 0, 7, 0, 10000, 0, 0, 2, "R7", 1, 0, 1);
    run_op(0, 0, 6, 0, 10000, 0, 20, 4, "R8", 1, 0, 1);
    run_op(0, 1, 6, 1, 10000, 0, 0, 2, "R7", 1, 1, 1);
    run_op(0, 0, 6, 1, 0, 0, 0, 3, "R10", 0, 0, 0);
    run_op(1, 0, 3, 0, 0, 0, 0, 0, "R4", 1, 1, 0);
    chk(st70_cyc - conf_cyc == WB + 2, "R4", "blank window gap", st70_cyc - conf_cyc, WB + 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule